// File: doc/BRIEF.md
# Column Sampling Switch Sequencer

This block is the digital sequencer behind a column-parallel image sensor in which every column owns two capacitor pairs and two CDS stages. For each row it steps through four phases on an external phase strobe: sample the reset levels, sample the signal levels, convert the current pixel, and convert the comparison pixel. While a sampling phase is active it drives the capacitor switch enables. During the two conversion phases it drives the select of a two-way output multiplexer, so that the current pixel always reaches the converter ahead of the comparison value.

The two capacitor pairs change roles on every row. On an odd row the first capacitor of each pair takes the reset level and the second takes the signal level. On an even row this is reversed. The pair that holds the current pixel alternates with the row parity, so the row sampled before stays stored while the next row is sampled and no row is read twice. A frame-start input restarts the row count at row 1, which is odd. The same input captures the comparison-mode inputs, and these drive a source select: the same pixel in the previous frame, the west neighbour, or the north neighbour.

Top module: `column_sample_seq`

## Requirements
- R1: While reset is held and right after it is released, row_idx is 0, row_odd is 0, phase_vec, rst_sw and sig_sw are 0, out_sel is 0 and cmp_src is 0 (previous frame).
- R2: A frame_start sets row_idx to 1 and row_odd to 1 and returns the phase to idle. It takes priority over row_adv and phase_stb in the same cycle.
- R3: Each row_adv without frame_start increments row_idx by one and toggles row_odd, so row_odd equals bit 0 of row_idx.
- R4: Each phase_stb moves phase_vec through idle (0000), reset-sample (0001), signal-sample (0010), convert-current (0100), convert-comparison (1000) and back to idle. At most one bit of phase_vec is ever set.
- R5: rst_sw bit k drives capacitor C(k+1). During reset-sample it is 0101 on an odd row and 1010 on an even row. It is 0000 in every other phase.
- R6: During signal-sample sig_sw is 1010 on an odd row and 0101 on an even row. It is 0000 in every other phase, so rst_sw and sig_sw are never both nonzero.
- R7: out_sel is 0 to pick the C1/C2 CDS stage and 1 to pick the C3/C4 stage. During convert-current it is 0 on odd rows and 1 on even rows. During convert-comparison it is the inverse. In other phases it is 0.
- R8: cmp_src is 00 for the previous frame when the latched intra flag is 0. When the intra flag is 1, it is 01 for the west neighbour if the latched west flag is 1, and 10 for the north neighbour if the west flag is 0.
- R9: mode_intra and mode_west are ignored except in a cycle with frame_start. cmp_src does not change between frame starts.
- R10: A row_adv in the middle of a phase sequence abandons that sequence, and phase_vec becomes 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Restart at row 1 and capture the mode inputs |
| row_adv | input | 1 | Advance to the next row |
| phase_stb | input | 1 | Step to the next sampling or conversion phase |
| mode_intra | input | 1 | 1 selects a neighbour comparison, 0 selects the previous frame |
| mode_west | input | 1 | 1 selects the west neighbour, 0 selects the north neighbour |
| row_idx | output | ROW_W | Active row number |
| row_odd | output | 1 | Parity of the active row |
| phase_vec | output | 4 | One-hot active phase |
| rst_sw | output | 4 | Reset-level sampling switch enables, bit k for C(k+1) |
| sig_sw | output | 4 | Signal-level sampling switch enables, bit k for C(k+1) |
| out_sel | output | 1 | Output multiplexer select |
| cmp_src | output | 2 | Comparison source select |

## Verification
Every output comes from a register, either directly or through decode logic with no clock in between. The effect of a strobe sampled at one rising edge is therefore visible from just after that edge and stays until the next strobe. The bench drives each stimulus at a falling edge, lets exactly one rising edge pass, and samples all outputs at the next falling edge. It then clears the strobes, and an idle cycle follows that does not change the state. The "ignored" cases are checked in the same way: after stray mode changes, cmp_src is read in the cycle that follows.

// File: rtl/column_seq_pkg.sv
// Shared types for the column sampling switch sequencer.
// Assumes two capacitor pairs per column; the pair count is the one place to change it.
package column_seq_pkg;
    localparam int NUM_PAIRS = 2;
    localparam int NUM_CAPS  = 2 * NUM_PAIRS;
    localparam int NUM_PH    = 4;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_RST  = 3'd1,
        PH_SIG  = 3'd2,
        PH_CUR  = 3'd3,
        PH_CMP  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        SRC_PREV  = 2'b00,
        SRC_WEST  = 2'b01,
        SRC_NORTH = 2'b10
    } src_e;
endpackage

// File: rtl/row_tracker.sv
// Row tracker: holds the active row number and its parity.
// A frame start loads row 1; each row advance increments it. Frame start wins.
module row_tracker #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             row_adv,
    output logic [ROW_W-1:0] row_idx,
    output logic             row_odd
);
    localparam logic [ROW_W-1:0] FIRST_ROW = ROW_W'(1);

    // Load or advance the row counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_idx <= '0;
        else if (frame_start)
            row_idx <= FIRST_ROW;
        else if (row_adv)
            row_idx <= row_idx + FIRST_ROW;
    end

    // Parity follows the low bit of the row number.
    always_comb row_odd = row_idx[0];
endmodule

// File: rtl/mode_latch.sv
// Mode latch: captures the comparison mode at frame start and maps it to a source select.
// Assumes the mode inputs are valid in the frame-start cycle; at other times they are ignored.
module mode_latch
    import column_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic mode_intra,
    input  logic mode_west,
    output src_e cmp_src
);
    logic intra_q;
    logic west_q;

    // Capture the mode flags only when a frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intra_q <= 1'b0;
            west_q  <= 1'b0;
        end else if (frame_start) begin
            intra_q <= mode_intra;
            west_q  <= mode_west;
        end
    end

    // Decode the latched flags into the comparison source.
    always_comb begin
        if (!intra_q)
            cmp_src = SRC_PREV;
        else if (west_q)
            cmp_src = SRC_WEST;
        else
            cmp_src = SRC_NORTH;
    end
endmodule

// File: rtl/phase_seq.sv
// Phase sequencer: steps through reset-sample, signal-sample, convert-current and
// convert-comparison, one phase per phase strobe, then returns to idle.
// A frame start or a row advance drops any sequence in progress.
module phase_seq
    import column_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              row_adv,
    input  logic              phase_stb,
    output phase_e            phase,
    output logic [NUM_PH-1:0] phase_vec
);
    phase_e nxt;

    // Next phase in the fixed order.
    always_comb begin
        case (phase)
            PH_IDLE: nxt = PH_RST;
            PH_RST:  nxt = PH_SIG;
            PH_SIG:  nxt = PH_CUR;
            PH_CUR:  nxt = PH_CMP;
            default: nxt = PH_IDLE;
        endcase
    end

    // Phase register; frame start and row advance take priority over the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_IDLE;
        else if (frame_start || row_adv)
            phase <= PH_IDLE;
        else if (phase_stb)
            phase <= nxt;
    end

    // One-hot view of the phase for the analog side.
    always_comb begin
        phase_vec = '0;
        case (phase)
            PH_RST:  phase_vec[0] = 1'b1;
            PH_SIG:  phase_vec[1] = 1'b1;
            PH_CUR:  phase_vec[2] = 1'b1;
            PH_CMP:  phase_vec[3] = 1'b1;
            default: phase_vec = '0;
        endcase
    end
endmodule

// File: rtl/switch_decode.sv
// Switch decode: turns the phase and the row parity into capacitor switch enables and
// the output multiplexer select. Index 2p is the first capacitor of pair p, 2p+1 the second.
// On odd rows the first capacitors hold reset levels; on even rows the roles swap.
module switch_decode
    import column_seq_pkg::*;
(
    input  phase_e              phase,
    input  logic                row_odd,
    output logic [NUM_CAPS-1:0] rst_sw,
    output logic [NUM_CAPS-1:0] sig_sw,
    output logic                out_sel
);
    logic in_rst;
    logic in_sig;

    // Phase flags for the two sampling phases.
    always_comb begin
        in_rst = (phase == PH_RST);
        in_sig = (phase == PH_SIG);
    end

    // Per pair: the parity decides which capacitor takes reset and which takes signal.
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        always_comb begin
            rst_sw[2*p]   = in_rst &&  row_odd;
            rst_sw[2*p+1] = in_rst && !row_odd;
            sig_sw[2*p]   = in_sig && !row_odd;
            sig_sw[2*p+1] = in_sig &&  row_odd;
        end
    end

    // The current pixel sits in the first pair on odd rows and in the second on even rows.
    always_comb begin
        case (phase)
            PH_CUR:  out_sel = !row_odd;
            PH_CMP:  out_sel =  row_odd;
            default: out_sel = 1'b0;
        endcase
    end
endmodule

// File: rtl/column_sample_seq.sv
// Column sampling switch sequencer, top level.
// Connects the row tracker, mode latch, phase sequencer and switch decode.
// Assumes the strobes are single-cycle pulses synchronous to clk.
module column_sample_seq
    import column_seq_pkg::*;
#(
    parameter int ROW_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                row_adv,
    input  logic                phase_stb,
    input  logic                mode_intra,
    input  logic                mode_west,
    output logic [ROW_W-1:0]    row_idx,
    output logic                row_odd,
    output logic [NUM_PH-1:0]   phase_vec,
    output logic [NUM_CAPS-1:0] rst_sw,
    output logic [NUM_CAPS-1:0] sig_sw,
    output logic                out_sel,
    output logic [1:0]          cmp_src
);
    phase_e phase;
    src_e   src;

    row_tracker #(.ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_adv(row_adv),
        .row_idx(row_idx), .row_odd(row_odd)
    );

    mode_latch u_mode (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .mode_intra(mode_intra), .mode_west(mode_west), .cmp_src(src)
    );

    phase_seq u_phase (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_adv(row_adv),
        .phase_stb(phase_stb), .phase(phase), .phase_vec(phase_vec)
    );

    switch_decode u_sw (
        .phase(phase), .row_odd(row_odd),
        .rst_sw(rst_sw), .sig_sw(sig_sw), .out_sel(out_sel)
    );

    // Present the source select as a plain vector.
    always_comb cmp_src = src;
endmodule

// File: rtl/column_seq_checker.sv
// Checker for the column sampling switch sequencer; bound to the top level below.
module column_seq_checker #(
    parameter int ROW_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             row_adv,
    input logic             phase_stb,
    input logic [ROW_W-1:0] row_idx,
    input logic             row_odd,
    input logic [3:0]       phase_vec,
    input logic [3:0]       rst_sw,
    input logic [3:0]       sig_sw,
    input logic             out_sel,
    input logic [1:0]       cmp_src
);
    p_frame_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (row_odd && phase_vec == 4'b0000));

    p_row_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_adv && !frame_start) |=> (row_odd != $past(row_odd)));

    p_single_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_vec));

    p_sig_after_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_vec[1]) |-> $past(phase_vec[0]));

    p_rst_sw_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_vec[0] |-> (rst_sw == 4'b0000));

    p_group_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !((|rst_sw) && (|sig_sw)));

    p_cur_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phase_vec[2] |-> (out_sel == !row_odd));

    p_cmp_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phase_vec[3] |-> (out_sel == row_odd));

    p_src_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_src != 2'b11);

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(cmp_src));

    p_abandon_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (row_adv && !frame_start) |=> (phase_vec == 4'b0000));
endmodule

bind column_sample_seq column_seq_checker #(.ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_adv(row_adv),
    .phase_stb(phase_stb), .row_idx(row_idx), .row_odd(row_odd),
    .phase_vec(phase_vec), .rst_sw(rst_sw), .sig_sw(sig_sw),
    .out_sel(out_sel), .cmp_src(cmp_src)
);

// File: tb/tb_column_sample_seq.sv
// Bench for the column sampling switch sequencer: a vector table walked by one loop,
// then directed tests for reset, priority, mid-sequence row advance and mode capture.
module tb_column_sample_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W      = 10;
    localparam int NVEC       = 19;

    // {fs, ra, ps, intra, west, phase[4], rst_sw[4], sig_sw[4], out_sel, cmp_src[2], odd}
    localparam logic [20:0] VEC [NVEC] = '{
        21'b1_0_0_1_1_0000_0000_0000_0_01_1,
        21'b0_0_1_1_1_0001_0101_0000_0_01_1,
        21'b0_0_1_1_1_0010_0000_1010_0_01_1,
        21'b0_0_1_1_1_0100_0000_0000_0_01_1,
        21'b0_0_1_1_1_1000_0000_0000_1_01_1,
        21'b0_0_1_1_1_0000_0000_0000_0_01_1,
        21'b0_1_0_1_1_0000_0000_0000_0_01_0,
        21'b0_0_1_1_1_0001_1010_0000_0_01_0,
        21'b0_0_1_1_1_0010_0000_0101_0_01_0,
        21'b0_0_1_1_1_0100_0000_0000_1_01_0,
        21'b0_0_1_1_1_1000_0000_0000_0_01_0,
        21'b0_0_1_1_1_0000_0000_0000_0_01_0,
        21'b1_0_0_1_0_0000_0000_0000_0_10_1,
        21'b0_1_0_1_0_0000_0000_0000_0_10_0,
        21'b0_1_0_1_0_0000_0000_0000_0_10_1,
        21'b0_0_1_1_0_0001_0101_0000_0_10_1,
        21'b1_0_0_0_1_0000_0000_0000_0_00_1,
        21'b0_0_1_0_1_0001_0101_0000_0_00_1,
        21'b0_0_1_0_1_0010_0000_1010_0_00_1
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0, row_adv = 1'b0, phase_stb = 1'b0;
    logic             mode_intra = 1'b0, mode_west = 1'b0;
    logic [ROW_W-1:0] row_idx;
    logic             row_odd;
    logic [3:0]       phase_vec, rst_sw, sig_sw;
    logic             out_sel;
    logic [1:0]       cmp_src;

    int n_checks = 0;
    int n_fail   = 0;

    column_sample_seq #(.ROW_W(ROW_W)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_adv(row_adv),
        .phase_stb(phase_stb), .mode_intra(mode_intra), .mode_west(mode_west),
        .row_idx(row_idx), .row_odd(row_odd), .phase_vec(phase_vec),
        .rst_sw(rst_sw), .sig_sw(sig_sw), .out_sel(out_sel), .cmp_src(cmp_src)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one stimulus at a falling edge, sample one rising edge later, clear strobes.
    task automatic step(input logic fs, input logic ra, input logic ps,
                        input logic intra, input logic west);
        @(negedge clk);
        frame_start = fs; row_adv = ra; phase_stb = ps;
        mode_intra = intra; mode_west = west;
        @(negedge clk);
        frame_start = 1'b0; row_adv = 1'b0; phase_stb = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values while reset is held
        check("R1 phase_vec", 16'(phase_vec), 16'h0);
        check("R1 rst_sw/sig_sw", 16'({rst_sw, sig_sw}), 16'h0);
        check("R1 row_idx/row_odd", 16'({row_idx, row_odd}), 16'h0);
        check("R1 out_sel/cmp_src", 16'({out_sel, cmp_src}), 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 16'({phase_vec, rst_sw, sig_sw}), 16'h0);

        // Table walk: R3 parity, R4 phase, R5 reset switches, R6 signal switches,
        // R7 mux select, R8 source select
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16]);
            check($sformatf("R4 phase_vec vec %0d", i), 16'(phase_vec), 16'(VEC[i][15:12]));
            check($sformatf("R5 rst_sw vec %0d", i), 16'(rst_sw), 16'(VEC[i][11:8]));
            check($sformatf("R6 sig_sw vec %0d", i), 16'(sig_sw), 16'(VEC[i][7:4]));
            check($sformatf("R7 out_sel vec %0d", i), 16'(out_sel), 16'(VEC[i][3]));
            check($sformatf("R8 cmp_src vec %0d", i), 16'(cmp_src), 16'(VEC[i][2:1]));
            check($sformatf("R3 row_odd vec %0d", i), 16'(row_odd), 16'(VEC[i][0]));
        end

        // R2: frame start beats row advance and phase strobe in the same cycle
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R2 row_idx after frame start", 16'(row_idx), 16'd1);
        check("R2 row_odd after frame start", 16'(row_odd), 16'd1);
        check("R2 phase idle after frame start", 16'(phase_vec), 16'h0);

        // R3: row advances count up from 1
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R3 row_idx second row", 16'(row_idx), 16'd2);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R3 row_idx third row", 16'(row_idx), 16'd3);
        check("R3 row_odd third row", 16'(row_odd), 16'd1);

        // R10: row advance in the middle of a sequence drops it
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R10 in signal phase before advance", 16'(phase_vec), 16'b0010);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R10 phase after mid-sequence advance", 16'(phase_vec), 16'h0);
        check("R10 switches after mid-sequence advance", 16'({rst_sw, sig_sw}), 16'h0);
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R10 restart at reset-sample, even row", 16'({phase_vec, rst_sw}), 16'h1A);

        // R9: mode changes outside frame start leave cmp_src at 00
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R9 cmp_src after intra/west change", 16'(cmp_src), 16'b00);
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R9 cmp_src after row advance with new mode", 16'(cmp_src), 16'b00);
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R9 cmp_src captured at frame start", 16'(cmp_src), 16'b10);

        // R1: reset returns everything to the idle values
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset state", 16'({phase_vec, rst_sw, sig_sw, out_sel, cmp_src, row_odd}), 16'h0);
        check("R1 re-reset row_idx", 16'(row_idx), 16'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule